// File: doc/BRIEF.md
# Sprite Attribute Page Copy Engine

This block moves one 256-byte page of the processor address space into the sprite attribute memory. Software starts a copy with a single write to a trigger register. The value written is the page number, which becomes the upper byte of the source address. The engine then becomes the bus master. It reads the page byte by byte in ascending order, and each byte it reads is written at once through the sprite data port.

The sprite data port has an auto-incrementing address. The copy does not always begin at sprite address zero. The engine loads its destination pointer from the current sprite address register value when the trigger is taken. That pointer steps once per byte and wraps from the top of the memory back to zero, while the source offset runs linearly from 0 to 255. Because exactly 256 bytes move, the pointer finishes back at its starting value. While a copy is in progress, `busy` is high and further trigger writes are ignored. A one-cycle `done` pulse marks the end of the copy.

Top module: `sprite_dma_engine`

## Requirements
- R1: While reset is high, and on the cycle after it, `busy`, `done`, `bus_rd` and `oam_we` are all 0.
- R2: A trigger write accepted while idle raises `busy` on the next cycle. The first read address is `{trig_page, 8'h00}`: the written value is the upper byte of the source address and the offset starts at zero.
- R3: A copy makes exactly 256 read cycles, at source addresses `{page, 0}` through `{page, 255}`, in ascending order, with each address read once.
- R4: A cycle never has both `bus_rd` and `oam_we` high. Every read cycle is followed by a write cycle whose `oam_wdata` equals the `bus_rdata` captured in that read cycle.
- R5: The first write of a copy goes to the `oam_addr_in` value sampled with the accepted trigger. Changes to `oam_addr_in` after that have no effect on the copy.
- R6: Each successive write address is one more than the previous one, modulo 256. With a start of 1, source offsets 0x00–0xFE land at 0x01–0xFF and offset 0xFF lands at 0x00.
- R7: When `done` is high, `oam_ptr` equals the start value, since the pointer has advanced by 256.
- R8: `busy` stays high for exactly 512 cycles. It then falls in the same cycle that `done` is high for a single cycle.
- R9: A trigger write while `busy` is high is ignored. The source page, destination, length and data of the running copy are unchanged, and no second copy follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Write strobe of the trigger register |
| trig_page | input | 8 | Source page number written with the trigger |
| oam_addr_in | input | 8 | Current sprite address register value |
| bus_addr | output | 16 | Source read address on the processor bus |
| bus_rd | output | 1 | Read strobe for the processor bus |
| bus_rdata | input | 8 | Read data, captured at the end of the read cycle |
| oam_we | output | 1 | Sprite memory write strobe |
| oam_waddr | output | 8 | Sprite memory write address |
| oam_wdata | output | 8 | Sprite memory write data |
| oam_ptr | output | 8 | Auto-incrementing destination pointer |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |

## Verification
The source model returns a byte that differs for every offset within a page. A reordered, skipped or repeated read therefore shows up as wrong sprite memory contents, not just as a wrong count. Start offsets of 0, 1 and 0xFF, plus random pages and starts, separate a destination fixed at zero, an off-by-one in the wrap and a pointer that fails to return to its start. One copy receives a second trigger with a different page and start part-way through, which shows whether a busy trigger corrupts the running copy or queues another one. Changing `oam_addr_in` after the trigger shows whether the start value is sampled once or followed continuously.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int SDMA_PAGE_W = 8;
    localparam int SDMA_IDX_W  = 8;
    localparam int SDMA_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } sdma_state_e;

    // per-cycle control word from the sequencer to the datapath
    typedef struct packed {
        logic load;   // trigger accepted: latch page and start
        logic rd;     // source read cycle
        logic wr;     // sprite memory write cycle
    } sdma_ctl_t;

    function automatic logic can_accept(sdma_state_e st);
        return (st == ST_IDLE) || (st == ST_FIN);
    endfunction

endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int IDX_W = SDMA_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_we,
    output sdma_ctl_t        ctl,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

    sdma_state_e      state_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_READ:  state_q <= ST_WRITE;
                ST_WRITE: begin
                    state_q <= (idx_q == IDX_LAST) ? ST_FIN : ST_READ;
                    idx_q   <= idx_q + 1'b1;
                end
                default: begin
                    if (trig_we) begin
                        state_q <= ST_READ;
                        idx_q   <= '0;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl.load = trig_we && can_accept(state_q);
        ctl.rd   = (state_q == ST_READ);
        ctl.wr   = (state_q == ST_WRITE);
    end

    assign idx  = idx_q;
    assign busy = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign done = (state_q == ST_FIN);

endmodule

// File: rtl/sdma_src_addr.sv
module sdma_src_addr
    import sdma_pkg::*;
#(
    parameter int PAGE_W = SDMA_PAGE_W,
    parameter int IDX_W  = SDMA_IDX_W,
    localparam int ADDR_W = PAGE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sdma_ctl_t         ctl,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (ctl.load)
            page_q <= page_in;
    end

    // page supplies the upper byte, offset runs linearly from zero
    assign addr = {page_q, idx};

endmodule

// File: rtl/sdma_dst_port.sv
module sdma_dst_port
    import sdma_pkg::*;
#(
    parameter int IDX_W  = SDMA_IDX_W,
    parameter int DATA_W = SDMA_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sdma_ctl_t         ctl,
    input  logic [IDX_W-1:0]  start_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  ptr,
    output logic [DATA_W-1:0] wdata
);
    logic [IDX_W-1:0]  ptr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            if (ctl.load)
                ptr_q <= start_in;
            else if (ctl.wr)
                ptr_q <= ptr_q + 1'b1;   // wraps modulo the memory size
            if (ctl.rd)
                data_q <= rdata;
        end
    end

    assign ptr   = ptr_q;
    assign wdata = data_q;

endmodule

// File: rtl/sprite_dma_engine.sv
module sprite_dma_engine
    import sdma_pkg::*;
#(
    parameter int PAGE_W = SDMA_PAGE_W,
    parameter int IDX_W  = SDMA_IDX_W,
    parameter int DATA_W = SDMA_DATA_W,
    localparam int ADDR_W = PAGE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_we,
    input  logic [PAGE_W-1:0] trig_page,
    input  logic [IDX_W-1:0]  oam_addr_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              oam_we,
    output logic [IDX_W-1:0]  oam_waddr,
    output logic [DATA_W-1:0] oam_wdata,
    output logic [IDX_W-1:0]  oam_ptr,
    output logic              busy,
    output logic              done
);
    sdma_ctl_t        ctl;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] ptr;

    sdma_seq #(.IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .trig_we (trig_we),
        .ctl     (ctl),
        .idx     (idx),
        .busy    (busy),
        .done    (done)
    );

    sdma_src_addr #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_src (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .page_in (trig_page),
        .idx     (idx),
        .addr    (bus_addr)
    );

    sdma_dst_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .start_in (oam_addr_in),
        .rdata    (bus_rdata),
        .ptr      (ptr),
        .wdata    (oam_wdata)
    );

    assign bus_rd    = ctl.rd;
    assign oam_we    = ctl.wr;
    assign oam_waddr = ptr;
    assign oam_ptr   = ptr;

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
    parameter int PAGE_W = 8,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = PAGE_W + IDX_W,
    localparam int BUSY_CYCLES = 2 * (1 << IDX_W),
    localparam int RUN_W = IDX_W + 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              oam_we,
    input logic [IDX_W-1:0]  oam_waddr,
    input logic [DATA_W-1:0] oam_wdata,
    input logic [IDX_W-1:0]  oam_ptr,
    input logic              busy,
    input logic              done
);
    logic [RUN_W-1:0] busy_run;
    logic [IDX_W-1:0] start_seen;
    logic             busy_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run   <= '0;
            start_seen <= '0;
            busy_d     <= 1'b0;
        end else begin
            busy_d   <= busy;
            busy_run <= busy ? busy_run + 1'b1 : '0;
            if (busy && !busy_d)
                start_seen <= oam_ptr;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !bus_rd && !oam_we));

    assert_src_ascend_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && $past(oam_we) && $past(bus_rd, 2)) |->
            (bus_addr - $past(bus_addr, 2)) == ADDR_W'(1));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && oam_we));

    assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (oam_we && oam_wdata == $past(bus_rdata)));

    assert_dst_step_R6: assert property (@(posedge clk) disable iff (rst)
        (oam_we && $past(oam_we, 2)) |->
            oam_waddr == IDX_W'($past(oam_waddr, 2) + 1'b1));

    assert_ptr_restored_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> oam_ptr == start_seen);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && busy_run == RUN_W'(BUSY_CYCLES)));

    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < RUN_W'(BUSY_CYCLES));

    assert_page_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            bus_addr[ADDR_W-1:IDX_W] == $past(bus_addr[ADDR_W-1:IDX_W]));

endmodule

bind sprite_dma_engine sdma_checker #(
    .PAGE_W (PAGE_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_sdma_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .oam_we    (oam_we),
    .oam_waddr (oam_waddr),
    .oam_wdata (oam_wdata),
    .oam_ptr   (oam_ptr),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_sprite_dma_engine.sv
`timescale 1ns/1ps
module test_sprite_dma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_we = 1'b0;
    logic [7:0]  trig_page = 8'h00;
    logic [7:0]  oam_addr_in = 8'h00;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        oam_we;
    logic [7:0]  oam_waddr;
    logic [7:0]  oam_wdata;
    logic [7:0]  oam_ptr;
    logic        busy;
    logic        done;

    always #4 clk = ~clk;   // 125 MHz

    sprite_dma_engine i_sprite_dma_engine (
        .clk(clk), .rst(rst), .trig_we(trig_we), .trig_page(trig_page),
        .oam_addr_in(oam_addr_in), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .oam_we(oam_we), .oam_waddr(oam_waddr),
        .oam_wdata(oam_wdata), .oam_ptr(oam_ptr), .busy(busy), .done(done)
    );

    // distinct byte for every offset within a page (37 is odd)
    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return (a[7:0] * 8'd37) ^ (a[15:8] * 8'd11) ^ 8'h5A;
    endfunction

    assign bus_rdata = src_byte(bus_addr);

    logic [7:0] oam_model [0:255];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    int   rd_cnt = 0, wr_cnt = 0, seq_err = 0;
    logic [7:0]  exp_page = 8'h00, exp_start = 8'h00;
    logic [15:0] first_rd = 16'h0000;

    always @(posedge clk) begin
        if (oam_we) oam_model[oam_waddr] <= oam_wdata;
        if (bus_rd) begin
            if (rd_cnt == 0) first_rd = bus_addr;
            if (bus_addr != {exp_page, 8'(rd_cnt)}) seq_err++;
            rd_cnt++;
        end
        if (oam_we) begin
            if (oam_waddr != 8'(exp_start + 8'(wr_cnt))) seq_err++;
            wr_cnt++;
        end
        if (bus_rd && oam_we) seq_err++;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [7:0] page, input logic [7:0] start,
                            input int retrig_at);
        int bcnt = 0;
        int guard = 0;
        int bad = 0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; seq_err = 0;
        exp_page = page; exp_start = start;
        trig_we = 1'b1; trig_page = page; oam_addr_in = start;
        @(negedge clk);
        trig_we = 1'b0;
        oam_addr_in = ~start;                        // R5: later changes ignored
        check(busy == 1'b1, "R2", "busy after trigger", busy, 1);
        while (!done && guard < 2000) begin
            if (busy) bcnt++;
            trig_we = (guard == retrig_at);          // R9: trigger while busy
            trig_page = page ^ 8'h3C;
            @(negedge clk);
            guard++;
        end
        trig_we = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R8", "done high, busy low at end",
              {busy, done}, 1);
        check(bcnt == 512, "R8", "busy cycles", bcnt, 512);
        check(first_rd == {page, 8'h00}, "R2", "first source address",
              first_rd, {page, 8'h00});
        check(rd_cnt == 256, "R3", "read count", rd_cnt, 256);
        check(wr_cnt == 256, "R4", "write count", wr_cnt, 256);
        check(seq_err == 0, "R6", "address order errors", seq_err, 0);
        check(oam_ptr == start, "R7", "pointer after copy", oam_ptr, start);
        for (int i = 0; i < 256; i++)
            if (oam_model[8'(start + 8'(i))] != src_byte({page, 8'(i)})) bad++;
        check(bad == 0, "R5", "sprite bytes misplaced", bad, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done single cycle", done, 0);
        check(busy == 1'b0, "R9", "no second copy", busy, 0);
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        check(!busy && !done && !bus_rd && !oam_we, "R1", "outputs in reset",
              {busy, done, bus_rd, oam_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !bus_rd && !oam_we, "R1", "outputs after reset",
              {busy, done, bus_rd, oam_we}, 0);

        run_xfer(8'h02, 8'h00, -1);
        run_xfer(8'h02, 8'h01, -1);                  // R6 wrap example
        check(oam_model[8'h01] == src_byte(16'h0200), "R6", "offset 0 at 0x01",
              oam_model[8'h01], src_byte(16'h0200));
        check(oam_model[8'h00] == src_byte(16'h02FF), "R6", "offset 0xFF at 0x00",
              oam_model[8'h00], src_byte(16'h02FF));
        run_xfer(8'hC7, 8'hFF, -1);
        check(oam_model[8'hFF] == src_byte(16'hC700), "R6", "start 0xFF first byte",
              oam_model[8'hFF], src_byte(16'hC700));
        run_xfer(8'h41, 8'h80, 37);                  // R9 mid-copy trigger
        run_xfer(8'h41, 8'h80, 0);                   // R9 trigger on first busy cycle
        for (int k = 0; k < 6; k++)
            run_xfer(8'($urandom), 8'($urandom), (k % 2 == 0) ? int'($urandom % 500) : -1);

        summary();
        $finish;
    end

endmodule